// File: doc/BRIEF.md
# Polled bridge transaction sequencer

This block is a hardware master that carries out a single 32-bit read or write through a register-mapped bridge for a simple client. The client supplies a target controller select, a port number, a byte offset inside that port's window, a direction and write data. The sequencer works out the downstream address and rejects requests that cannot be mapped. It writes a command word to the bridge's command register and then reads the bridge's status register repeatedly, waiting a fixed interval between reads. It stops when the transfer finishes, fails or runs out of retries.

When an allowed error bit is seen, the sequencer writes zero to the status register before it reports. A configuration input narrows the set of error bits that are honoured, so that two sticky summary bits that cannot be cleared can be ignored. Results come back as a one-cycle completion pulse with a result code and read data. A request is taken only while the sequencer is idle.

Top module: `pbt_sequencer`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and fields presented while busy have no effect. Each transaction ends with `rsp_done` high for one cycle, carrying `rsp_code` 0 (success), 1 (parameter error) or 2 (hardware error). Out of reset, `req_ready` is 1 and both `rsp_done` and `br_req` are 0.
- R2: A request is rejected with code 1 and no bus request in any of three cases: `req_master` is 3, `req_port` is above 7, or the computed address is above 0x00FFFFFF. The address is computed without truncation, so offsets near 2^32 are also rejected.
- R3: The address is the controller base, plus `req_port` × 0x8000, plus `req_offset`. The base is 0x40000 for selects 0 and 1 and 0x80000 for select 2. `br_bridge` is 1 for select 1 and 0 for selects 0 and 2.
- R4: The command goes out as a write to register 0. Bits 63:32 of the word hold bit 31 = 1 for a write, bits 30:29 = 2'b11, bits 28:24 = 0 and bits 23:0 = the address. Bits 31:0 hold the write data for a write and 0 for a read. While `br_req` is high and `br_ack` is low, all bus outputs hold steady.
- R5: The first status read (register 1) follows the command acknowledge with no idle cycle. After each busy status response, `br_req` stays low for exactly POLL_CYCLES = CLK_MHZ × POLL_US cycles before the next status read.
- R6: In the status word (bits 63:32 of `br_rdata`), bit 16 is busy and bit 17 is read-valid. Polling stops on the first response that has busy clear or any honoured error bit set.
- R7: The honoured error set is 0x09F0FCFC. With `cfg_skip_sticky` high, taken while idle, bits 15 and 7 are removed from it. A removed bit has no effect on either the stop decision or the result.
- R8: An honoured error takes precedence over completion. The sequencer writes zero to register 1 of the same bridge and then reports code 2.
- R9: After MAX_RETRIES + 1 busy responses with no honoured error, the result is code 2 and no status clear is written.
- R10: A read that completes returns code 0. The data is bits 31:0 of the final response if read-valid is set, and 0xFFFFFFFF if it is not. A completed write returns code 0 with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_skip_sticky | input | 1 | Remove the two sticky summary bits from the honoured error set |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_master | input | 2 | Controller select: 0, 1, 2 legal, 3 rejected |
| req_port | input | 4 | Port number, legal 0 to 7 |
| req_offset | input | 32 | Byte offset within the port window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | Result code, valid with `rsp_done` |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |
| br_req | output | 1 | Bridge register access request |
| br_we | output | 1 | Access is a register write |
| br_bridge | output | 1 | Which of two bridges is addressed |
| br_reg | output | 2 | Bridge register: 0 command, 1 status |
| br_wdata | output | 64 | Register write data |
| br_ack | input | 1 | Access accepted; read data valid this cycle |
| br_rdata | input | 64 | Register read data |

## Verification
Completion and error detection can meet in one status response, when busy is clear and an error bit is set in the same word. The bench returns such words, both after several busy polls and on the first poll. It judges the outcome by the result code, by whether a zero was written to the status register of the right bridge, and by the number of status reads. The same coincidence is then repeated with a sticky bit while the skip configuration is set, where completion must win. A busy word that carries a removed sticky bit must run to the retry limit.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

    typedef enum logic [1:0] {
        RC_OK    = 2'd0,
        RC_PARAM = 2'd1,
        RC_HWERR = 2'd2
    } rc_e;

    typedef enum logic [1:0] {
        MS_CASC0 = 2'd0,
        MS_CASC1 = 2'd1,
        MS_HUB0  = 2'd2,
        MS_NONE  = 2'd3
    } msel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_WAIT,
        ST_CLEAR
    } seq_state_e;

    localparam logic [1:0]  REG_CMD  = 2'd0;
    localparam logic [1:0]  REG_STAT = 2'd1;

    localparam logic [31:0] STAT_BUSY   = 32'h0001_0000;
    localparam logic [31:0] STAT_RVALID = 32'h0002_0000;
    localparam logic [31:0] ERR_BUS     = 32'h09F0_0000;
    localparam logic [31:0] ERR_CASC    = 32'h0000_FC00;
    localparam logic [31:0] ERR_HUB     = 32'h0000_00FC;
    localparam logic [31:0] ERR_ALL     = ERR_BUS | ERR_CASC | ERR_HUB;
    localparam logic [31:0] STICKY_KEEP = 32'hFFFF_7F7F;

    localparam logic [31:0] CMD_WRITE = 32'h8000_0000;
    localparam logic [31:0] CMD_SZ32  = 32'h6000_0000;

    localparam logic [32:0] ADDR_MAX      = 33'h0_00FF_FFFF;
    localparam logic [32:0] BASE_CASC     = 33'h0_0004_0000;
    localparam logic [32:0] BASE_HUB      = 33'h0_0008_0000;
    localparam int          PORT_SHIFT    = 15;
    localparam logic [3:0]  PORT_MAX      = 4'd7;

    typedef struct packed {
        logic        ok;
        logic        bridge;
        logic [23:0] addr;
    } route_t;

    typedef struct packed {
        logic        busy;
        logic        err;
        logic [31:0] data;
    } stat_t;

    function automatic logic [63:0] make_cmd(input logic wr,
                                             input logic [23:0] addr,
                                             input logic [31:0] wdata);
        logic [31:0] hi;
        hi = (wr ? CMD_WRITE : 32'h0) | CMD_SZ32 | {8'h00, addr};
        return {hi, (wr ? wdata : 32'h0)};
    endfunction

    function automatic logic [31:0] err_mask(input logic skip_sticky);
        return skip_sticky ? (ERR_ALL & STICKY_KEEP) : ERR_ALL;
    endfunction

endpackage

// File: rtl/pbt_route.sv
module pbt_route
    import pbt_pkg::*;
(
    input  logic [1:0]  sel,
    input  logic [3:0]  port,
    input  logic [31:0] offset,
    output route_t      route
);
    logic [32:0] base;
    logic        sel_ok;
    logic        port_ok;
    logic [32:0] port_off;
    logic [32:0] sum;

    always_comb begin
        base   = BASE_CASC;
        sel_ok = 1'b1;
        unique case (msel_e'(sel))
            MS_CASC0: base = BASE_CASC;
            MS_CASC1: base = BASE_CASC;
            MS_HUB0:  base = BASE_HUB;
            default:  sel_ok = 1'b0;
        endcase
    end

    assign port_ok  = (port <= PORT_MAX);
    assign port_off = {30'h0, port[2:0]} << PORT_SHIFT;
    assign sum      = base + port_off + {1'b0, offset};

    assign route.ok     = sel_ok && port_ok && (sum <= ADDR_MAX);
    assign route.bridge = (msel_e'(sel) == MS_CASC1);
    assign route.addr   = sum[23:0];

endmodule

// File: rtl/pbt_stat_eval.sv
module pbt_stat_eval
    import pbt_pkg::*;
(
    input  logic [63:0] rdata,
    input  logic [31:0] mask,
    output stat_t       ev
);
    logic [31:0] word;
    logic        rvalid;

    assign word   = rdata[63:32];
    assign rvalid = |(word & STAT_RVALID);

    assign ev.busy = |(word & STAT_BUSY);
    assign ev.err  = |(word & mask);
    assign ev.data = rvalid ? rdata[31:0] : 32'hFFFF_FFFF;

endmodule

// File: rtl/pbt_poll_timer.sv
module pbt_poll_timer #(
    parameter int INTERVAL = 1000,
    parameter int RETRIES  = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic consume,
    output logic exhausted,
    output logic wait_done
);
    localparam int IW = (INTERVAL < 1) ? 1 : $clog2(INTERVAL + 1);
    localparam int RW = (RETRIES < 1) ? 1 : $clog2(RETRIES + 1);
    localparam logic [IW-1:0] IVL_LOAD = IW'(INTERVAL - 1);
    localparam logic [RW-1:0] RET_LOAD = RW'(RETRIES);

    logic [IW-1:0] ivl_cnt;
    logic [RW-1:0] ret_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_cnt <= '0;
            ret_cnt <= '0;
        end else begin
            if (arm) begin
                ret_cnt <= RET_LOAD;
            end else if (consume && ret_cnt != '0) begin
                ret_cnt <= ret_cnt - 1'b1;
            end

            if (consume) begin
                ivl_cnt <= IVL_LOAD;
            end else if (ivl_cnt != '0) begin
                ivl_cnt <= ivl_cnt - 1'b1;
            end
        end
    end

    assign exhausted = (ret_cnt == '0);
    assign wait_done = (ivl_cnt == '0);

endmodule

// File: rtl/pbt_sequencer.sv
module pbt_sequencer
    import pbt_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int POLL_US     = 10,
    parameter int MAX_RETRIES = 120
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_skip_sticky,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_master,
    input  logic [3:0]  req_port,
    input  logic [31:0] req_offset,
    input  logic        req_write,
    input  logic [31:0] req_wdata,
    output logic        rsp_done,
    output logic [1:0]  rsp_code,
    output logic [31:0] rsp_rdata,
    output logic        br_req,
    output logic        br_we,
    output logic        br_bridge,
    output logic [1:0]  br_reg,
    output logic [63:0] br_wdata,
    input  logic        br_ack,
    input  logic [63:0] br_rdata
);
    localparam int POLL_CYCLES = CLK_MHZ * POLL_US;

    seq_state_e  state;
    route_t      route;
    stat_t       ev;
    logic [31:0] mask_q;
    logic [63:0] cmd_q;
    logic        bridge_q;
    logic        is_read_q;
    logic        accept;
    logic        arm;
    logic        consume;
    logic        exhausted;
    logic        wait_done;
    logic        poll_ack;

    pbt_route u_route (
        .sel    (req_master),
        .port   (req_port),
        .offset (req_offset),
        .route  (route)
    );

    pbt_stat_eval u_eval (
        .rdata (br_rdata),
        .mask  (mask_q),
        .ev    (ev)
    );

    pbt_poll_timer #(
        .INTERVAL (POLL_CYCLES),
        .RETRIES  (MAX_RETRIES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .consume   (consume),
        .exhausted (exhausted),
        .wait_done (wait_done)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign arm       = accept && route.ok;
    assign poll_ack  = (state == ST_POLL) && br_ack;
    assign consume   = poll_ack && !ev.err && ev.busy && !exhausted;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mask_q    <= ERR_ALL;
            cmd_q     <= '0;
            bridge_q  <= 1'b0;
            is_read_q <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_code  <= RC_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    mask_q <= err_mask(cfg_skip_sticky);
                    if (accept) begin
                        if (route.ok) begin
                            cmd_q     <= make_cmd(req_write, route.addr, req_wdata);
                            bridge_q  <= route.bridge;
                            is_read_q <= !req_write;
                            state     <= ST_CMD;
                        end else begin
                            rsp_done  <= 1'b1;
                            rsp_code  <= RC_PARAM;
                            rsp_rdata <= '0;
                        end
                    end
                end
                ST_CMD: begin
                    if (br_ack) state <= ST_POLL;
                end
                ST_POLL: begin
                    if (br_ack) begin
                        if (ev.err) begin
                            state <= ST_CLEAR;
                        end else if (!ev.busy) begin
                            rsp_done  <= 1'b1;
                            rsp_code  <= RC_OK;
                            rsp_rdata <= is_read_q ? ev.data : 32'h0;
                            state     <= ST_IDLE;
                        end else if (exhausted) begin
                            rsp_done  <= 1'b1;
                            rsp_code  <= RC_HWERR;
                            rsp_rdata <= '0;
                            state     <= ST_IDLE;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_done) state <= ST_POLL;
                end
                ST_CLEAR: begin
                    if (br_ack) begin
                        rsp_done  <= 1'b1;
                        rsp_code  <= RC_HWERR;
                        rsp_rdata <= '0;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        br_req    = 1'b0;
        br_we     = 1'b0;
        br_reg    = REG_STAT;
        br_wdata  = '0;
        br_bridge = bridge_q;
        unique case (state)
            ST_CMD: begin
                br_req   = 1'b1;
                br_we    = 1'b1;
                br_reg   = REG_CMD;
                br_wdata = cmd_q;
            end
            ST_POLL: begin
                br_req = 1'b1;
            end
            ST_CLEAR: begin
                br_req = 1'b1;
                br_we  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pbt_sequencer_chk.sv
module pbt_sequencer_chk
    import pbt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic [1:0]  rsp_code,
    input logic        br_req,
    input logic        br_we,
    input logic        br_bridge,
    input logic [1:0]  br_reg,
    input logic [63:0] br_wdata,
    input logic        br_ack
);
    logic bus_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_used <= 1'b0;
        end else if (req_valid && req_ready) begin
            bus_used <= 1'b0;
        end else if (br_req) begin
            bus_used <= 1'b1;
        end
    end

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !br_req); // R1

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> rsp_code != 2'd3); // R1

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_code == RC_PARAM) |-> !bus_used); // R2

    AST_CMD_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_reg == REG_CMD) |-> (br_we && br_wdata[62:61] == 2'b11 && br_wdata[60:56] == 5'd0)); // R4

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (br_req && !br_ack) |=> (br_req && $stable(br_we) && $stable(br_reg) && $stable(br_bridge) && $stable(br_wdata))); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_we && br_reg == REG_STAT) |-> br_wdata == 64'h0); // R8

endmodule

bind pbt_sequencer pbt_sequencer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_code  (rsp_code),
    .br_req    (br_req),
    .br_we     (br_we),
    .br_bridge (br_bridge),
    .br_reg    (br_reg),
    .br_wdata  (br_wdata),
    .br_ack    (br_ack)
);

// File: tb/pbt_sequencer_bench.sv
module pbt_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_MHZ = 1;
    localparam int T_US  = 3;
    localparam int T_RET = 4;
    localparam int GAP   = T_MHZ * T_US;

    localparam logic [31:0] BUSY  = 32'h0001_0000;
    localparam logic [31:0] RV    = 32'h0002_0000;
    localparam logic [31:0] EFULL = 32'h09F0_FCFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_skip_sticky = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_master = '0;
    logic [3:0]  req_port = '0;
    logic [31:0] req_offset = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        br_req;
    logic        br_we;
    logic        br_bridge;
    logic [1:0]  br_reg;
    logic [63:0] br_wdata;
    logic        br_ack = 1'b0;
    logic [63:0] br_rdata = '0;

    int          vectors = 0;
    int          miscompares = 0;

    int          busy_n = 0;
    logic [31:0] fin_stat = '0;
    logic [31:0] fin_low = '0;
    int          cmd_cnt = 0;
    int          stat_rd = 0;
    int          clr_wr = 0;
    logic [63:0] cmd_seen = '0;
    logic        cmd_br = 1'b0;
    logic        clr_br = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbt_sequencer #(
        .CLK_MHZ     (T_MHZ),
        .POLL_US     (T_US),
        .MAX_RETRIES (T_RET)
    ) u_pbt_sequencer (
        .clk             (clk),
        .rst             (rst),
        .cfg_skip_sticky (cfg_skip_sticky),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_master      (req_master),
        .req_port        (req_port),
        .req_offset      (req_offset),
        .req_write       (req_write),
        .req_wdata       (req_wdata),
        .rsp_done        (rsp_done),
        .rsp_code        (rsp_code),
        .rsp_rdata       (rsp_rdata),
        .br_req          (br_req),
        .br_we           (br_we),
        .br_bridge       (br_bridge),
        .br_reg          (br_reg),
        .br_wdata        (br_wdata),
        .br_ack          (br_ack),
        .br_rdata        (br_rdata)
    );

    // bridge model: one-cycle acknowledge, scripted status words
    always @(negedge clk) begin
        if (br_ack) begin
            br_ack = 1'b0;
        end else if (br_req && !rst) begin
            br_ack = 1'b1;
            if (br_we && br_reg == 2'd0) begin
                cmd_cnt  = cmd_cnt + 1;
                cmd_seen = br_wdata;
                cmd_br   = br_bridge;
            end else if (br_we && br_reg == 2'd1) begin
                if (br_wdata == 64'h0) clr_wr = clr_wr + 1;
                clr_br = br_bridge;
            end else begin
                br_rdata = {(stat_rd < busy_n) ? BUSY : fin_stat, fin_low};
                stat_rd  = stat_rd + 1;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int ms, input int port, input logic [31:0] off,
                       input bit wr, input logic [31:0] wd, input int bn,
                       input logic [31:0] fs, input logic [31:0] fl,
                       input bit skip, input bit hold);
        longint      base;
        longint      sum;
        bit          ok;
        bit          exp_br;
        logic [31:0] mask;
        logic [31:0] s;
        int          exp_code;
        int          exp_reads;
        int          exp_clr;
        logic [31:0] exp_data;
        logic [63:0] exp_cmd;
        int          gaps;
        logic [1:0]  got_code;
        logic [31:0] got_data;

        base   = (ms == 2) ? 64'h80000 : 64'h40000;
        sum    = base + longint'(port) * 64'h8000 + longint'(off);
        ok     = (ms < 3) && (port < 8) && (sum <= 64'hFF_FFFF);
        exp_br = (ms == 1);
        mask   = skip ? (EFULL & 32'hFFFF_7F7F) : EFULL;
        exp_cmd = {(wr ? 32'h8000_0000 : 32'h0) | 32'h6000_0000 | (sum[31:0] & 32'h00FF_FFFF),
                   wr ? wd : 32'h0};
        exp_reads = 0;
        exp_clr   = 0;
        exp_code  = 1;
        exp_data  = 32'h0;
        if (ok) begin
            for (int i = 0; i <= T_RET; i++) begin
                s = (i < bn) ? BUSY : fs;
                exp_reads = exp_reads + 1;
                if ((s & mask) != 0) begin
                    exp_code = 2; exp_clr = 1; break;
                end
                if ((s & BUSY) == 0) begin
                    exp_code = 0;
                    exp_data = wr ? 32'h0 : (((s & RV) != 0) ? fl : 32'hFFFF_FFFF);
                    break;
                end
                if (i == T_RET) exp_code = 2;
            end
        end

        @(negedge clk);
        cfg_skip_sticky = skip;
        busy_n = bn; fin_stat = fs; fin_low = fl;
        cmd_cnt = 0; stat_rd = 0; clr_wr = 0;
        @(negedge clk);
        req_master = 2'(ms); req_port = 4'(port); req_offset = off;
        req_write = wr; req_wdata = wd; req_valid = 1'b1;
        gaps = 0;
        forever begin
            @(negedge clk);
            if (!hold) req_valid = 1'b0;
            else begin
                req_port = 4'd5; req_offset = 32'h0000_0100; req_wdata = ~wd;
            end
            if (rsp_done) break;
            if (!br_req) gaps = gaps + 1;
        end
        req_valid = 1'b0;
        got_code = rsp_code;
        got_data = rsp_rdata;

        chk($sformatf("R1 result code ms=%0d port=%0d off=%0h", ms, port, off),
            64'(got_code), 64'(exp_code));
        if (!ok) begin
            chk("R2 no command on rejected request", 64'(cmd_cnt), 64'd0);
        end else begin
            chk("R3 R4 command word", cmd_seen, exp_cmd);
            chk("R3 bridge select", 64'(cmd_br), 64'(exp_br));
            chk("R1 single command per transaction", 64'(cmd_cnt), 64'd1);
            chk("R6 R9 status read count", 64'(stat_rd), 64'(exp_reads));
            chk("R8 status clear count", 64'(clr_wr), 64'(exp_clr));
            if (exp_clr != 0) chk("R8 clear bridge", 64'(clr_br), 64'(exp_br));
            chk("R5 idle cycles between polls", 64'(gaps), 64'((exp_reads - 1) * GAP));
            if (exp_code == 0) chk("R10 returned data", 64'(got_data), 64'(exp_data));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors = vectors + 1;
        miscompares = miscompares + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int ports[5];
        ports = '{0, 1, 7, 8, 12};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset done low", 64'(rsp_done), 64'd0);
        chk("R1 reset bus idle", 64'(br_req), 64'd0);

        // address map sweep, including the exact limit and one past it
        for (int ms = 0; ms < 4; ms++) begin
            for (int pi = 0; pi < 5; pi++) begin
                longint lim;
                lim = 64'hFF_FFFF - ((ms == 2) ? 64'h80000 : 64'h40000)
                      - longint'(ports[pi] % 8) * 64'h8000;
                run(ms, ports[pi], 32'h0, 1'b0, 32'h0, 1, RV, 32'hA5A5_0000 + 32'(pi), 1'b0, 1'b0);
                run(ms, ports[pi], 32'h0000_123C, 1'b1, 32'hC0DE_0000 + 32'(ms), 0, 32'h0, 32'h0, 1'b0, 1'b0);
                run(ms, ports[pi], 32'(lim), 1'b0, 32'h0, 0, RV, 32'h1111_2222, 1'b0, 1'b0);
                run(ms, ports[pi], 32'(lim + 1), 1'b1, 32'h3, 0, 32'h0, 32'h0, 1'b0, 1'b0);
            end
        end

        // R2 overflow beyond 32 bits must still be rejected
        run(0, 7, 32'hFFFF_FFFF, 1'b0, 32'h0, 0, RV, 32'h0, 1'b0, 1'b0);
        // R5 R6 several busy responses then done
        run(2, 3, 32'h40, 1'b0, 32'h0, 3, RV, 32'hDEAD_BEEF, 1'b0, 1'b0);
        // R9 timeout
        run(1, 2, 32'h80, 1'b0, 32'h0, 20, RV, 32'h0, 1'b0, 1'b0);
        // R6 R8 error seen while still busy
        run(1, 4, 32'h10, 1'b1, 32'h77, 2, BUSY | 32'h0000_0004, 32'h0, 1'b0, 1'b0);
        // R8 error and completion in the same response
        run(0, 1, 32'h20, 1'b0, 32'h0, 1, RV | 32'h0010_0000, 32'h1234, 1'b0, 1'b0);
        run(2, 0, 32'h20, 1'b0, 32'h0, 0, 32'h0800_0000, 32'h1234, 1'b0, 1'b0);
        // R10 read completes without read-valid
        run(0, 6, 32'h8, 1'b0, 32'h0, 2, 32'h0, 32'h5555_AAAA, 1'b0, 1'b0);
        // R7 sticky bit 15 with completion: honoured, then skipped
        run(0, 0, 32'h4, 1'b0, 32'h0, 0, RV | 32'h0000_8000, 32'h0BAD, 1'b0, 1'b0);
        run(0, 0, 32'h4, 1'b0, 32'h0, 0, RV | 32'h0000_8000, 32'h0600D, 1'b1, 1'b0);
        // R7 sticky bit 7 with busy while skipped runs to timeout
        run(2, 5, 32'h4, 1'b0, 32'h0, 0, BUSY | 32'h0000_0080, 32'h0, 1'b1, 1'b0);
        // R7 bit 6 is not sticky and still stops polling when skipped
        run(2, 5, 32'h4, 1'b0, 32'h0, 0, BUSY | 32'h0000_0040, 32'h0, 1'b1, 1'b0);
        // R1 request fields changed and held valid while busy
        run(1, 3, 32'h300, 1'b1, 32'hFACE_0001, 2, 32'h0, 32'h0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R1 held request not taken after done", 64'(cmd_cnt), 64'd1);

        summary();
        $finish;
    end

endmodule